// File: doc/BRIEF.md
# Masked Dual Alarm and Interrupt Pin Unit

This block sits next to a calendar counter in a real-time clock. Once per second, after the counters have settled, it compares the current BCD time against two programmable alarm sets. Each alarm byte carries a mask bit that removes that field from the compare, so the mask pattern chooses the repeat rate. The rates run from every tick up to a full day-or-date match. The first alarm covers seconds, minutes, hours and day/date. The second has no seconds byte and only fires when the seconds counter reads 00. A match latches a sticky flag. The host can only clear a flag, by writing a zero to it.

A single open-drain pin is shared by two uses. In interrupt mode it pulls low while any flag that is enabled is set. In wave mode it follows one of four divided-clock taps, picked by a two-bit rate code. While the chip runs from its secondary supply, the pin is released unless a battery-enable bit is set. The configuration register is loaded through a write strobe. Its reset value selects wave mode at the fastest tap, with both interrupt enables off.

Top module: `alarm_irq_unit`

## Requirements
- R1: An alarm-1 field (seconds, minutes, hours, day/date) takes part in the compare only when bit 7 of its alarm byte is 0. With all four bit-7 masks at 1, alarm 1 matches on every tick.
- R2: In a day/date alarm byte, bit 6 = 1 compares bits 5:0 with the day-of-week input, and bit 6 = 0 compares them with the date input.
- R3: Alarm 2 compares minutes, hours and day/date under the same bit-7 masks, and can only match on a tick where the seconds input equals 8'h00.
- R4: Flags (flags[0] for alarm 1, flags[1] for alarm 2) are set only at a clock edge where sec_tick is high and the alarm matches. The new value is visible after that edge.
- R5: With flag_we high, a 0 in flag_wdata bit i clears flag i and a 1 leaves it unchanged. Without a write, a set flag stays set. A match in the same cycle as a clearing write wins.
- R6: With irq_mode = 1, pin_drive_low equals (flags[0] & irq_en[0]) | (flags[1] & irq_en[1]).
- R7: With irq_mode = 0, pin_drive_low is the inverse of wave_taps[rate]. Rate 00 selects tap 0 (1 Hz), 01 tap 1 (4.096 kHz), 10 tap 2 (8.192 kHz) and 11 tap 3 (32.768 kHz).
- R8: While on_backup = 1 and bat_en = 0, pin_drive_low is 0 in either mode.
- R9: After reset, flags = 00, rate = 11, irq_mode = 0, irq_en = 00 and bat_en = 0.
- R10: cfg_we loads bat_en, rate, irq_mode and irq_en at the clock edge. The pin uses the old setting in the write cycle and the new one afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sec_tick | input | 1 | One-cycle pulse once the time inputs hold the new second |
| tm_sec | input | 8 | Current seconds, BCD |
| tm_min | input | 8 | Current minutes, BCD |
| tm_hour | input | 8 | Current hours, BCD with 12/24 bit |
| tm_dow | input | 8 | Current day of week |
| tm_date | input | 8 | Current date of month, BCD |
| a1_sec | input | 8 | Alarm 1 seconds, bit 7 mask |
| a1_min | input | 8 | Alarm 1 minutes, bit 7 mask |
| a1_hour | input | 8 | Alarm 1 hours, bit 7 mask |
| a1_dd | input | 8 | Alarm 1 day/date, bit 7 mask, bit 6 select |
| a2_min | input | 8 | Alarm 2 minutes, bit 7 mask |
| a2_hour | input | 8 | Alarm 2 hours, bit 7 mask |
| a2_dd | input | 8 | Alarm 2 day/date, bit 7 mask, bit 6 select |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_bat_en | input | 1 | Keep pin active on backup supply |
| cfg_rate | input | 2 | Wave tap select |
| cfg_irq_mode | input | 1 | 1 = interrupt, 0 = wave |
| cfg_irq_en | input | 2 | Per-alarm interrupt enables |
| flag_we | input | 1 | Flag write strobe |
| flag_wdata | input | 2 | Flag write data, 0 clears |
| wave_taps | input | 4 | Divided-clock levels, index = rate code |
| on_backup | input | 1 | Running from secondary supply |
| flags | output | 2 | Sticky alarm flags |
| pin_drive_low | output | 1 | Open-drain enable, 1 pulls the pin low |

## Verification
A comparator with a wrong mask or selector sense shows up on the flags output one edge after the tick carrying that time: either a flag appears that the time does not call for, or an expected one is missing. A flag register that clears itself or ignores a write shows on the flags at the next sample. If the stray state is an enabled flag in interrupt mode, the pin also changes in that same cycle. A wrong configuration reset or a wrong tap index is seen on the pin before any tick occurs, as soon as the taps are driven to distinct levels.

// File: rtl/alm_pkg.sv
package alm_pkg;
   localparam int FLD_W  = 8;
   localparam int NUM_AL = 2;
   localparam int RATE_W = 2;
   localparam int NUM_TAP = 1 << RATE_W;

   typedef struct packed {
      logic              bat_en;
      logic [RATE_W-1:0] rate;
      logic              irq_mode;
      logic [NUM_AL-1:0] irq_en;
   } alm_cfg_t;

   localparam alm_cfg_t CFG_RESET = '{bat_en: 1'b0, rate: {RATE_W{1'b1}},
                                      irq_mode: 1'b0, irq_en: '0};
endpackage

// File: rtl/alm_match.sv
module alm_match #(
   parameter int FW      = 8,
   parameter int MASK_B  = 7,
   parameter int SEL_B   = 6,
   parameter bit HAS_SEC = 1'b1
) (
   input  logic [FW-1:0] tm_sec,
   input  logic [FW-1:0] tm_min,
   input  logic [FW-1:0] tm_hour,
   input  logic [FW-1:0] tm_dow,
   input  logic [FW-1:0] tm_date,
   input  logic [FW-1:0] al_sec,
   input  logic [FW-1:0] al_min,
   input  logic [FW-1:0] al_hour,
   input  logic [FW-1:0] al_dd,
   output logic          hit
);
   localparam int VAL_W = MASK_B;
   localparam int DD_W  = SEL_B;

   if (FW != MASK_B + 1) begin : g_bad_width
      $error("alm_match: mask bit must be the top bit of each field");
   end
   if (SEL_B >= MASK_B) begin : g_bad_sel
      $error("alm_match: day/date select must lie below the mask bit");
   end

   logic sec_ok, min_ok, hour_ok, dd_ok;
   logic [FW-1:0] dd_src;

   // seconds: alarm 1 compares under its mask, alarm 2 waits for second 00
   if (HAS_SEC) begin : g_sec_field
      assign sec_ok = al_sec[MASK_B] |
                      (tm_sec == {{(FW-VAL_W){1'b0}}, al_sec[VAL_W-1:0]});
   end else begin : g_sec_zero
      assign sec_ok = (tm_sec == '0) & ~al_sec[MASK_B] &
                      (al_sec[VAL_W-1:0] == '0);
   end

   assign min_ok  = al_min[MASK_B] |
                    (tm_min == {{(FW-VAL_W){1'b0}}, al_min[VAL_W-1:0]});
   assign hour_ok = al_hour[MASK_B] |
                    (tm_hour == {{(FW-VAL_W){1'b0}}, al_hour[VAL_W-1:0]});

   assign dd_src = al_dd[SEL_B] ? tm_dow : tm_date;
   assign dd_ok  = al_dd[MASK_B] |
                   (dd_src == {{(FW-DD_W){1'b0}}, al_dd[DD_W-1:0]});

   assign hit = sec_ok & min_ok & hour_ok & dd_ok;
endmodule

// File: rtl/alm_flags.sv
module alm_flags #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic [N-1:0] hit,
   input  logic         wr_en,
   input  logic [N-1:0] wr_data,
   output logic [N-1:0] flag_q
);
   if (N < 1) begin : g_bad_n
      $error("alm_flags: need at least one flag");
   end

   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flag_q[i] <= 1'b0;
         else if (tick && hit[i])
            flag_q[i] <= 1'b1;
         else if (wr_en && !wr_data[i])
            flag_q[i] <= 1'b0;
      end

      a_r4_set_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(flag_q[i]) |-> $past(tick && hit[i]));
      a_r5_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_data[i] && !(tick && hit[i])) |=> (flag_q[i] == $past(flag_q[i])));
      a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (!wr_en && flag_q[i]) |=> flag_q[i]);
   end
endmodule

// File: rtl/alm_outmux.sv
module alm_outmux
   import alm_pkg::*;
#(
   parameter int N  = 2,
   parameter int NT = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  alm_cfg_t      cfg,
   input  logic [N-1:0]  flags,
   input  logic [NT-1:0] taps,
   input  logic          on_backup,
   output logic          pin_low
);
   localparam int SELW = $clog2(NT);

   if (NT != (1 << RATE_W)) begin : g_bad_taps
      $error("alm_outmux: tap count must match the rate code range");
   end
   if (SELW != RATE_W) begin : g_bad_sel
      $error("alm_outmux: select width mismatch");
   end

   logic irq_any, wave_low, muted;

   assign irq_any  = |(flags & cfg.irq_en);
   assign wave_low = ~taps[cfg.rate];
   assign muted    = on_backup & ~cfg.bat_en;
   assign pin_low  = muted ? 1'b0 : (cfg.irq_mode ? irq_any : wave_low);

   a_r8_backup_release: assert property (@(posedge clk) disable iff (!rst_n)
      (on_backup && !cfg.bat_en) |-> !pin_low);
   a_r6_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.irq_mode && !on_backup && (flags[0] & cfg.irq_en[0])) |-> pin_low);
endmodule

// File: rtl/alarm_irq_unit.sv
module alarm_irq_unit
   import alm_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_tick,
   input  logic [FLD_W-1:0]  tm_sec,
   input  logic [FLD_W-1:0]  tm_min,
   input  logic [FLD_W-1:0]  tm_hour,
   input  logic [FLD_W-1:0]  tm_dow,
   input  logic [FLD_W-1:0]  tm_date,
   input  logic [FLD_W-1:0]  a1_sec,
   input  logic [FLD_W-1:0]  a1_min,
   input  logic [FLD_W-1:0]  a1_hour,
   input  logic [FLD_W-1:0]  a1_dd,
   input  logic [FLD_W-1:0]  a2_min,
   input  logic [FLD_W-1:0]  a2_hour,
   input  logic [FLD_W-1:0]  a2_dd,
   input  logic              cfg_we,
   input  logic              cfg_bat_en,
   input  logic [RATE_W-1:0] cfg_rate,
   input  logic              cfg_irq_mode,
   input  logic [NUM_AL-1:0] cfg_irq_en,
   input  logic              flag_we,
   input  logic [NUM_AL-1:0] flag_wdata,
   input  logic [NUM_TAP-1:0] wave_taps,
   input  logic              on_backup,
   output logic [NUM_AL-1:0] flags,
   output logic              pin_drive_low
);
   if (NUM_AL != 2) begin : g_bad_count
      $error("alarm_irq_unit: exactly two alarm sets are wired");
   end

   alm_cfg_t cfg_q;
   logic [NUM_AL-1:0] hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cfg_q <= CFG_RESET;
      else if (cfg_we)
         cfg_q <= '{bat_en: cfg_bat_en, rate: cfg_rate,
                    irq_mode: cfg_irq_mode, irq_en: cfg_irq_en};
   end

   alm_match #(.FW(FLD_W), .HAS_SEC(1'b1)) u_match1 (
      .tm_sec(tm_sec), .tm_min(tm_min), .tm_hour(tm_hour),
      .tm_dow(tm_dow), .tm_date(tm_date),
      .al_sec(a1_sec), .al_min(a1_min), .al_hour(a1_hour), .al_dd(a1_dd),
      .hit(hit[0]));

   alm_match #(.FW(FLD_W), .HAS_SEC(1'b0)) u_match2 (
      .tm_sec(tm_sec), .tm_min(tm_min), .tm_hour(tm_hour),
      .tm_dow(tm_dow), .tm_date(tm_date),
      .al_sec('0), .al_min(a2_min), .al_hour(a2_hour), .al_dd(a2_dd),
      .hit(hit[1]));

   alm_flags #(.N(NUM_AL)) u_flags (
      .clk(clk), .rst_n(rst_n), .tick(sec_tick), .hit(hit),
      .wr_en(flag_we), .wr_data(flag_wdata), .flag_q(flags));

   alm_outmux #(.N(NUM_AL), .NT(NUM_TAP)) u_out (
      .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .flags(flags),
      .taps(wave_taps), .on_backup(on_backup), .pin_low(pin_drive_low));

   a_r3_second_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[1]) |-> ($past(tm_sec) == '0));
endmodule

// File: tb/alarm_irq_unit_tb.sv
module alarm_irq_unit_tb;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n, sec_tick, cfg_we, cfg_bat_en, cfg_irq_mode, flag_we, on_backup;
   logic [7:0] tm_sec, tm_min, tm_hour, tm_dow, tm_date;
   logic [7:0] a1_sec, a1_min, a1_hour, a1_dd, a2_min, a2_hour, a2_dd;
   logic [1:0] cfg_rate, cfg_irq_en, flag_wdata, flags;
   logic [3:0] wave_taps;
   logic pin_drive_low;

   alarm_irq_unit u_dut (.*);

   int checks = 0, errors = 0;
   logic [1:0] mf;
   logic mbat, mmode;
   logic [1:0] mrate, mie;
   logic last_pin;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] bcd(input int v);
      return {4'(v / 10), 4'(v % 10)};
   endfunction

   function automatic bit fld(input logic [7:0] al, input logic [7:0] tm);
      return al[7] || (tm == {1'b0, al[6:0]});
   endfunction

   function automatic bit ddm(input logic [7:0] al);
      logic [7:0] src;
      src = al[6] ? tm_dow : tm_date;
      return al[7] || (src == {2'b00, al[5:0]});
   endfunction

   function automatic bit hit1();
      return fld(a1_sec, tm_sec) && fld(a1_min, tm_min) && fld(a1_hour, tm_hour) && ddm(a1_dd);
   endfunction

   function automatic bit hit2();
      return (tm_sec == 8'h00) && fld(a2_min, tm_min) && fld(a2_hour, tm_hour) && ddm(a2_dd);
   endfunction

   function automatic bit exp_pin();
      if (on_backup && !mbat) return 1'b0;
      if (mmode) return |(mf & mie);
      return !wave_taps[mrate];
   endfunction

   task automatic cyc();
      logic [1:0] nf;
      #1;
      last_pin = pin_drive_low;
      chk(pin_drive_low == exp_pin(), "R6 R7 R8 pin", pin_drive_low, exp_pin());
      nf = mf & (flag_we ? flag_wdata : 2'b11);
      if (sec_tick && hit1()) nf[0] = 1'b1;
      if (sec_tick && hit2()) nf[1] = 1'b1;
      mf = nf;
      if (cfg_we) begin
         mbat = cfg_bat_en; mrate = cfg_rate; mmode = cfg_irq_mode; mie = cfg_irq_en;
      end
      @(negedge clk);
      chk(flags == mf, "R4 R5 flags", flags, mf);
   endtask

   task automatic strobes_off();
      sec_tick = 0; cfg_we = 0; flag_we = 0; flag_wdata = 2'b11;
   endtask

   task automatic clear_flags();
      strobes_off(); flag_we = 1; flag_wdata = 2'b00; cyc(); flag_we = 0;
   endtask

   task automatic put_cfg(input bit b, input logic [1:0] r, input bit m, input logic [1:0] e);
      cfg_we = 1; cfg_bat_en = b; cfg_rate = r; cfg_irq_mode = m; cfg_irq_en = e;
   endtask

   initial begin
      #(4 * 150000);
      chk(1'b0, "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      rst_n = 0; strobes_off(); on_backup = 0; wave_taps = 4'b0000;
      cfg_bat_en = 0; cfg_rate = 0; cfg_irq_mode = 0; cfg_irq_en = 0;
      tm_sec = 8'h31; tm_min = 8'h15; tm_hour = 8'h09; tm_dow = 8'h03; tm_date = 8'h22;
      a1_sec = 8'h00; a1_min = 8'h00; a1_hour = 8'h00; a1_dd = 8'h00;
      a2_min = 8'h00; a2_hour = 8'h00; a2_dd = 8'h00;
      mf = 0; mbat = 0; mrate = 2'b11; mmode = 0; mie = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R9: reset state, wave mode on the fastest tap
      chk(flags == 2'b00, "R9 flags after reset", flags, 0);
      wave_taps = 4'b0111; cyc();
      chk(last_pin == 1'b1, "R9 R7 tap3 low drives pin", last_pin, 1);
      wave_taps = 4'b1000; cyc();
      chk(last_pin == 1'b0, "R9 R7 tap3 high releases pin", last_pin, 0);

      // R1: all masks set -> every tick
      a1_sec = 8'h80; a1_min = 8'h80; a1_hour = 8'h80; a1_dd = 8'h80;
      sec_tick = 1; cyc(); sec_tick = 0;
      chk(flags[0] == 1'b1, "R1 all masked fires", flags[0], 1);

      // R5: write 1 keeps, write 0 clears
      flag_we = 1; flag_wdata = 2'b11; cyc();
      chk(flags[0] == 1'b1, "R5 write one keeps", flags[0], 1);
      flag_wdata = 2'b10; cyc(); flag_we = 0;
      chk(flags[0] == 1'b0, "R5 write zero clears", flags[0], 0);
      cyc();
      chk(flags[0] == 1'b0, "R4 no tick no set", flags[0], 0);

      // R1: seconds compared, others masked
      a1_sec = 8'h30; tm_sec = 8'h31; sec_tick = 1; cyc();
      chk(flags[0] == 1'b0, "R1 seconds mismatch", flags[0], 0);
      tm_sec = 8'h30; cyc(); sec_tick = 0;
      chk(flags[0] == 1'b1, "R1 seconds match", flags[0], 1);
      clear_flags();

      // R2: day/date selector, all fields compared
      a1_sec = 8'h30; a1_min = 8'h15; a1_hour = 8'h09; a1_dd = 8'h43;
      sec_tick = 1; cyc(); sec_tick = 0;
      chk(flags[0] == 1'b1, "R2 day-of-week match", flags[0], 1);
      clear_flags();
      a1_dd = 8'h03; sec_tick = 1; cyc(); sec_tick = 0;
      chk(flags[0] == 1'b0, "R2 date select ignores day", flags[0], 0);
      a1_dd = 8'h22; sec_tick = 1; cyc(); sec_tick = 0;
      chk(flags[0] == 1'b1, "R2 date match", flags[0], 1);
      clear_flags();

      // R3: alarm 2 needs second 00
      a1_sec = 8'h59; a1_min = 8'h80; a1_hour = 8'h80; a1_dd = 8'h80;
      a2_min = 8'h80; a2_hour = 8'h80; a2_dd = 8'h80;
      tm_sec = 8'h01; sec_tick = 1; cyc();
      chk(flags[1] == 1'b0, "R3 second 01 no fire", flags[1], 0);
      tm_sec = 8'h00; cyc(); sec_tick = 0;
      chk(flags[1] == 1'b1, "R3 second 00 fires", flags[1], 1);

      // R10 R6: interrupt mode, enables
      put_cfg(0, 2'b00, 1, 2'b01); cyc(); cfg_we = 0;
      chk(last_pin == 1'b0, "R10 old setting in write cycle", last_pin, 0);
      cyc();
      chk(last_pin == 1'b0, "R6 disabled flag no drive", last_pin, 0);
      put_cfg(0, 2'b00, 1, 2'b10); cyc(); cfg_we = 0;
      cyc();
      chk(last_pin == 1'b1, "R6 R10 enabled flag drives", last_pin, 1);
      cyc();
      chk(last_pin == 1'b1, "R6 holds until cleared", last_pin, 1);

      // R8: backup gating
      on_backup = 1; cyc();
      chk(last_pin == 1'b0, "R8 backup releases pin", last_pin, 0);
      put_cfg(1, 2'b00, 1, 2'b10); cyc(); cfg_we = 0; cyc();
      chk(last_pin == 1'b1, "R8 bat_en keeps pin", last_pin, 1);
      on_backup = 0;

      // R5: set wins over clear in the same cycle
      a1_sec = 8'h80; tm_sec = 8'h12;
      sec_tick = 1; flag_we = 1; flag_wdata = 2'b00; cyc(); strobes_off();
      chk(flags == 2'b01, "R5 match beats clear", flags, 1);

      // R7: each tap in wave mode
      for (int r = 0; r < 4; r++) begin
         put_cfg(0, 2'(r), 0, 2'b00); cyc(); cfg_we = 0;
         wave_taps = ~(4'b0001 << r); cyc();
         chk(last_pin == 1'b1, "R7 selected tap low", last_pin, 1);
         wave_taps = 4'b0001 << r; cyc();
         chk(last_pin == 1'b0, "R7 selected tap high", last_pin, 0);
      end

      // random mix, checked every cycle by the model in cyc
      for (int n = 0; n < 3000; n++) begin
         tm_sec = ($urandom % 3 == 0) ? 8'h00 : bcd($urandom % 60);
         tm_min = bcd($urandom % 60); tm_hour = bcd($urandom % 24);
         tm_dow = bcd(1 + $urandom % 7); tm_date = bcd(1 + $urandom % 31);
         a1_sec  = {1'($urandom), ($urandom % 2) ? tm_sec[6:0]  : bcd($urandom % 60)};
         a1_min  = {1'($urandom), ($urandom % 2) ? tm_min[6:0]  : bcd($urandom % 60)};
         a1_hour = {1'($urandom), ($urandom % 2) ? tm_hour[6:0] : bcd($urandom % 24)};
         a2_min  = {1'($urandom), ($urandom % 2) ? tm_min[6:0]  : bcd($urandom % 60)};
         a2_hour = {1'($urandom), ($urandom % 2) ? tm_hour[6:0] : bcd($urandom % 24)};
         a1_dd = {1'($urandom), 1'($urandom), 6'h00};
         a1_dd[5:0] = a1_dd[6] ? tm_dow[5:0] : tm_date[5:0];
         if ($urandom % 4 == 0) a1_dd[5:0] = 6'($urandom);
         a2_dd = {1'($urandom), 1'($urandom), 6'h00};
         a2_dd[5:0] = a2_dd[6] ? tm_dow[5:0] : tm_date[5:0];
         sec_tick = 1'($urandom);
         flag_we = ($urandom % 4 == 0); flag_wdata = 2'($urandom);
         cfg_we = ($urandom % 8 == 0);
         cfg_bat_en = 1'($urandom); cfg_rate = 2'($urandom);
         cfg_irq_mode = 1'($urandom); cfg_irq_en = 2'($urandom);
         on_backup = ($urandom % 4 == 0);
         wave_taps = 4'($urandom);
         cyc();
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule